// File: doc/BRIEF.md
# Two-Level DMA Channel Priority Arbiter

This block picks one of eight DMA channels for service. Each channel carries a two-bit software priority level, and among channels on the same level a fixed order by channel number decides. A channel takes part only when it is both enabled and requesting. The winner is captured in a register, and it stays granted until the channel signals completion with a one-cycle done pulse. After that pulse the arbiter goes idle for one cycle, and then it arbitrates again.

The block is built to be instantiated twice with no shared state. One copy orders access on the memory side and the other on the peripheral side. Bus protocol, FIFOs and address generation are handled elsewhere.

Top module: `dmaPrioArb`

## Requirements
- R1: After reset, `grantOh` is all zeros, `grantIdx` is 0 and `grantValid` is low.
- R2: Only a channel with both its `chReq` bit and its `chEn` bit high is eligible. While idle with no eligible channel, `grantValid` stays low and `grantOh` stays zero.
- R3: The level encoding is 0 = low, 1 = medium, 2 = high, 3 = ultra high. An eligible channel on a higher level always wins over any channel on a lower level.
- R4: Among eligible channels on the winning level, the lowest channel number wins. Channel 0 is first and channel 7 is last.
- R5: The grant is registered. If an eligible channel is present at a clock edge while the arbiter is idle, the grant for the winner is visible right after that edge.
- R6: While a grant is held, `grantOh` and `grantIdx` stay stable. Changes on `chReq`, `chEn` or `chPrio`, and done pulses from channels that are not granted, do not move the grant.
- R7: A `chDone` pulse on the bit of the granted channel clears `grantValid` and `grantOh` at the next edge. The next arbitration happens at the edge after that.
- R8: The arbiter samples priority fields only at an arbitration edge. A value written while a grant is held decides the next arbitration.
- R9: `grantOh` has at most one bit set. When `grantValid` is high, that bit is at position `grantIdx`.
- R10: The field of channel i in `chPrio` occupies bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chReq | input | 8 | Per-channel request |
| chEn | input | 8 | Per-channel enable |
| chPrio | input | 16 | Two-bit priority level per channel, channel i at [2i+1:2i] |
| chDone | input | 8 | One-cycle completion pulse per channel |
| grantOh | output | 8 | One-hot grant |
| grantIdx | output | 3 | Number of the granted channel |
| grantValid | output | 1 | A grant is held |

## Verification
The bench applies each request pattern at a falling edge. The grant it produces becomes visible one rising edge later, so the bench checks it at the next falling edge. A done pulse for the granted channel clears the grant after exactly one rising edge, and the bench checks at the following falling edge that `grantValid` is low. Checks of a held grant are spread across several cycles while the bench changes requests, enables, priorities and done pulses on channels that are not granted. Re-arbitration is checked two edges after the done pulse, so that the idle cycle in between is observed on its own.

// File: rtl/dmaPrioArbPkg.sv
package dmaPrioArbPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobe_t;

  // Status from datapath back to control
  typedef struct packed {
    logic anyEligible;
    logic doneHit;
  } arbStatus_t;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arbState_t;

endpackage

// File: rtl/dmaPrioArbCtrl.sv
module dmaPrioArbCtrl
  import dmaPrioArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStatus_t status,
  output arbStrobe_t strobe
);

  arbState_t ctrlState, ctrlStateNext;

  always_comb begin
    strobe        = '0;
    ctrlStateNext = ctrlState;
    unique case (ctrlState)
      ARB_IDLE: begin
        if (status.anyEligible) begin
          strobe.loadGrant = 1'b1;
          ctrlStateNext    = ARB_BUSY;
        end
      end
      ARB_BUSY: begin
        if (status.doneHit) begin
          strobe.clearGrant = 1'b1;
          ctrlStateNext     = ARB_IDLE;
        end
      end
      default: ctrlStateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlState <= ARB_IDLE;
    else       ctrlState <= ctrlStateNext;
  end

  // R6: stay busy until the granted channel reports done
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ARB_BUSY && !status.doneHit) |=> (ctrlState == ARB_BUSY));

  // R7: done returns to idle for one cycle
  p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ARB_BUSY && status.doneHit) |=> (ctrlState == ARB_IDLE));

  // R2: idle with nothing eligible stays idle
  p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ARB_IDLE && !status.anyEligible) |=> (ctrlState == ARB_IDLE));

endmodule

// File: rtl/dmaPrioArbDp.sv
module dmaPrioArbDp
  import dmaPrioArbPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 2,
  localparam int NUM_LEVELS = 1 << PRIO_W,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chReq,
  input  logic [NUM_CH-1:0]        chEn,
  input  logic [NUM_CH*PRIO_W-1:0] chPrio,
  input  logic [NUM_CH-1:0]        chDone,
  input  arbStrobe_t               strobe,
  output arbStatus_t               status,
  output logic [NUM_CH-1:0]        grantOh,
  output logic [IDX_W-1:0]         grantIdx,
  output logic                     grantValid
);

  logic [NUM_CH-1:0] eligible;
  logic [NUM_LEVELS-1:0][NUM_CH-1:0] levelSel;
  logic [NUM_LEVELS-1:0] levelHit;
  logic [PRIO_W-1:0] topLevel;
  logic [NUM_CH-1:0] topMask;
  logic [NUM_CH-1:0] winOh;
  logic [IDX_W-1:0]  winIdx;

  assign eligible = chReq & chEn;

  // Per-level membership masks
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign levelSel[lv][ch] = (chPrio[ch*PRIO_W +: PRIO_W] == PRIO_W'(lv));
    end
    assign levelHit[lv] = |(eligible & levelSel[lv]);
  end

  // Highest populated level
  always_comb begin
    topLevel = '0;
    for (int lv = 0; lv < NUM_LEVELS; lv++) begin
      if (levelHit[lv]) topLevel = PRIO_W'(lv);
    end
  end

  assign topMask = eligible & levelSel[topLevel];

  // Lowest channel number within the level
  always_comb begin
    winOh  = '0;
    winIdx = '0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (topMask[ch]) begin
        winOh  = NUM_CH'(1) << ch;
        winIdx = IDX_W'(ch);
      end
    end
  end

  assign status.anyEligible = |eligible;
  assign status.doneHit     = |(chDone & grantOh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOh    <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else if (strobe.clearGrant) begin
      grantOh    <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else if (strobe.loadGrant) begin
      grantOh    <= winOh;
      grantIdx   <= winIdx;
      grantValid <= 1'b1;
    end
  end

  // R9: one-hot grant consistent with index and valid
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh) && (grantValid == (grantOh != '0)));

  p_idx_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grantOh[grantIdx]);

  // R2: a new grant goes only to a channel that was eligible
  p_eligible_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGrant |=> ((grantOh & $past(eligible)) != '0));

  // R6: grant stable while held and not completed
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !status.doneHit) |=> ($stable(grantOh) && $stable(grantIdx)));

  // R7: done on the granted channel releases
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && status.doneHit) |=> !grantValid);

endmodule

// File: rtl/dmaPrioArb.sv
module dmaPrioArb
  import dmaPrioArbPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chReq,
  input  logic [NUM_CH-1:0]        chEn,
  input  logic [NUM_CH*PRIO_W-1:0] chPrio,
  input  logic [NUM_CH-1:0]        chDone,
  output logic [NUM_CH-1:0]        grantOh,
  output logic [IDX_W-1:0]         grantIdx,
  output logic                     grantValid
);

  arbStrobe_t strobe;
  arbStatus_t status;

  dmaPrioArbCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  dmaPrioArbDp #(
    .NUM_CH (NUM_CH),
    .PRIO_W (PRIO_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .chReq      (chReq),
    .chEn       (chEn),
    .chPrio     (chPrio),
    .chDone     (chDone),
    .strobe     (strobe),
    .status     (status),
    .grantOh    (grantOh),
    .grantIdx   (grantIdx),
    .grantValid (grantValid)
  );

endmodule

// File: tb/dmaPrioArb_tb_top.sv
`timescale 1ns/1ps
module dmaPrioArb_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  chReq = '0;
  logic [7:0]  chEn = '0;
  logic [15:0] chPrio = '0;
  logic [7:0]  chDone = '0;
  logic [7:0]  grantOh;
  logic [2:0]  grantIdx;
  logic        grantValid;

  int checks = 0;
  int fails = 0;
  logic [31:0] rng = 32'h1badcafe;

  always #2 clk = ~clk;

  dmaPrioArb dut_i (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chEn(chEn),
    .chPrio(chPrio), .chDone(chDone),
    .grantOh(grantOh), .grantIdx(grantIdx), .grantValid(grantValid)
  );

  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Reference: highest level first, then lowest channel number (R3, R4, R10)
  function automatic int refWinner(input logic [7:0] rq, input logic [7:0] en,
                                   input logic [15:0] pr);
    int best = -1;
    for (int lv = 3; lv >= 0 && best < 0; lv--) begin
      for (int ch = 0; ch < 8 && best < 0; ch++) begin
        if (rq[ch] && en[ch] && (pr[ch*2 +: 2] == lv[1:0])) best = ch;
      end
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkGrant(input int exp, input string tag);
    if (exp < 0) begin
      check(!grantValid && grantOh == 8'h0, {tag, " R2 no grant"},
            {23'd0, grantValid, grantOh}, 32'h0);
    end else begin
      check(grantValid && grantOh == (8'h1 << exp) && grantIdx == exp[2:0],
            {tag, " R3/R4 winner"}, {20'd0, grantIdx, grantValid, grantOh},
            {20'd0, exp[2:0], 1'b1, 8'h1 << exp});
    end
  endtask

  // Arbitrate from idle, check, then release (R5, R7)
  task automatic runCase(input logic [7:0] rq, input logic [7:0] en,
                         input logic [15:0] pr, input string tag);
    int exp;
    exp = refWinner(rq, en, pr);
    chReq = rq; chEn = en; chPrio = pr; chDone = '0;
    @(posedge clk); @(negedge clk);
    checkGrant(exp, tag);
    chDone = grantOh;
    chReq = '0;
    @(posedge clk); @(negedge clk);
    chDone = '0;
    check(!grantValid && grantOh == 8'h0, {tag, " R7 released"},
          {23'd0, grantValid, grantOh}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int exp;
    logic [7:0] heldOh;
    repeat (3) @(negedge clk);
    check(grantOh == 8'h0 && grantIdx == 3'd0 && !grantValid, "R1 reset",
          {20'd0, grantIdx, grantValid, grantOh}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: requests without enable, enable without requests
    runCase(8'hFF, 8'h00, 16'hFFFF, "R2 disabled");
    runCase(8'h00, 8'hFF, 16'hFFFF, "R2 idle");

    // R4 sweep: all request vectors, every channel on one level
    for (int r = 0; r < 256; r++) runCase(r[7:0], 8'hFF, 16'h5555, "R4 sweep");

    // R3 sweep: all request vectors, mixed levels (R10 layout)
    for (int r = 0; r < 256; r++) begin
      logic [15:0] pr;
      for (int ch = 0; ch < 8; ch++) pr[ch*2 +: 2] = 2'((ch * 3 + 1) % 4);
      runCase(r[7:0], 8'hFF, pr, "R3 sweep");
    end

    // Pseudo-random requests, enables and levels
    for (int n = 0; n < 300; n++) begin
      logic [7:0] rq, en;
      logic [15:0] pr;
      rng = nextRng(rng); rq = rng[7:0]; en = rng[15:8] | rng[23:16];
      rng = nextRng(rng); pr = rng[15:0];
      runCase(rq, en, pr, "R3 random");
    end

    // R6 / R8: hold while inputs move, then new priority decides
    chReq = 8'b1000_0010; chEn = 8'hFF;
    chPrio = '0; chPrio[3:2] = 2'd1; chPrio[15:14] = 2'd0;
    @(posedge clk); @(negedge clk);
    checkGrant(1, "R5 registered");
    heldOh = grantOh;
    chPrio[15:14] = 2'd3;
    chReq = 8'hFF; chEn = 8'hF0;
    chDone = 8'b1000_0000;
    @(posedge clk); @(negedge clk);
    check(grantValid && grantOh == heldOh && grantIdx == 3'd1, "R6 held",
          {20'd0, grantIdx, grantValid, grantOh}, {20'd0, 3'd1, 1'b1, heldOh});
    chDone = '0; chEn = 8'h00;
    @(posedge clk); @(negedge clk);
    check(grantValid && grantOh == heldOh, "R6 held no enable",
          {23'd0, grantValid, grantOh}, {23'd0, 1'b1, heldOh});
    chReq = 8'b1000_0010; chEn = 8'hFF;
    chDone = 8'b0000_0010;
    @(posedge clk); @(negedge clk);
    chDone = '0;
    check(!grantValid, "R7 idle gap", {31'd0, grantValid}, 32'h0);
    @(posedge clk); @(negedge clk);
    exp = 7;
    checkGrant(exp, "R8 new priority");
    chDone = grantOh; chReq = '0;
    @(posedge clk); @(negedge clk);
    chDone = '0;
    check(!grantValid, "R7 final release", {31'd0, grantValid}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule